// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach the 8-bit registers of a serial-bus controller through one 64-bit command register. The host writes a command word. The word holds a busy flag, a register selector, a direction flag and a payload byte. The bridge then performs exactly one access on its internal register port. When a read completes, the bridge puts the result into the low byte of the same word and drops the busy flag. The host polls that flag to see when the access has finished.

The same selector code names the clock-control register on a write and the status register on a read. A separate selector form addresses the clock high-phase register. A command that arrives while an access is in progress is discarded. The internal access takes `LATENCY` cycles, with a default of 4.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, `host_rdata` is all zeros and `acc_stb` is low.
- R2: A host write with bit 63 set, made while bit 63 of the stored word is clear, starts an access. Bit 63 of `host_rdata` reads 1 for exactly `LATENCY` cycles and then clears.
- R3: A host write made while bit 63 reads 1 is discarded. The running access, its selector and the stored word are unaffected.
- R4: Bit 56 is the direction flag. When it is 1 the access is a read and `acc_wr` is 0. When it is 0 the access is a write and `acc_wr` is 1.
- R5: If bits 59 and 58 are both 1, bits 34:32 pick the target register, reported on `acc_sel`:
  - code 1 selects data (`acc_sel`=1);
  - code 2 selects control (`acc_sel`=2);
  - code 3 selects clock control on a write (`acc_sel`=3) and status on a read (`acc_sel`=4);
  - code 7 selects soft reset (`acc_sel`=5).
- R6: If bit 59 is 1 and bit 58 is 0, the target is the clock high-phase register (`acc_sel`=6), whatever bits 34:32 hold.
- R7: Any other selector form (bit 59 clear, or an extended code of 0, 4, 5 or 6) produces no strobe. Bit 63 still clears after `LATENCY` cycles and the rest of the word is unchanged.
- R8: On a write access, `acc_wdata` carries bits 7:0 of the command, and the stored word keeps its low byte.
- R9: On a read access, bits 7:0 of the stored word are replaced by the `acc_rdata` value present during the strobe. Bits 62:8 are preserved.
- R10: Each accepted command with a mapped selector raises `acc_stb` for exactly one cycle, the last cycle in which bit 63 reads 1.
- R11: A host write with bit 63 clear, made while idle, is stored as written and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command register |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command register contents |
| acc_stb | output | 1 | Internal access strobe, one cycle |
| acc_wr | output | 1 | 1 for a register write, 0 for a read |
| acc_sel | output | 3 | Target register code |
| acc_wdata | output | 8 | Write payload |
| acc_rdata | input | 8 | Read data from the addressed register |

## Verification
Each kind of internal fault shows up at the ports within one command. A wrong selector decode shows on `acc_sel` in the strobe cycle. A wrong busy counter shows as a busy flag that clears earlier or later than `LATENCY` cycles after acceptance. A lost busy guard shows as a second strobe, or as a changed word after a write made while busy. A merge error on readback shows in the very next `host_rdata` value after the flag clears. The bench sweeps every combination of extended bits, selector code and direction, each with distinct payload and filler bits, so a fault cannot hide behind a repeated pattern.

// File: rtl/ind_reg_bridge_pkg.sv
package ind_reg_bridge_pkg;
    localparam int WORD_W = 64;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    localparam int BIT_VALID = 63;
    localparam int BIT_EXT1  = 59;
    localparam int BIT_EXT0  = 58;
    localparam int BIT_READ  = 56;
    localparam int CODE_LO   = 32;
    localparam int CODE_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        TGT_NONE   = 3'd0,
        TGT_DATA   = 3'd1,
        TGT_CTRL   = 3'd2,
        TGT_CLKCTL = 3'd3,
        TGT_STAT   = 3'd4,
        TGT_RESET  = 3'd5,
        TGT_THP    = 3'd6
    } target_e;
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
    import ind_reg_bridge_pkg::*;
(
    input  logic [WORD_W-1:0] cmd,
    output target_e           target,
    output logic              is_write
);
    logic [CODE_W-1:0] code;
    logic              ext_hi;
    logic              ext_lo;

    always_comb begin
        code     = cmd[CODE_LO +: CODE_W];
        ext_hi   = cmd[BIT_EXT1];
        ext_lo   = cmd[BIT_EXT0];
        is_write = ~cmd[BIT_READ];
        target   = TGT_NONE;
        if (ext_hi && !ext_lo) begin
            target = TGT_THP;
        end else if (ext_hi && ext_lo) begin
            case (code)
                3'd1:    target = TGT_DATA;
                3'd2:    target = TGT_CTRL;
                3'd3:    target = is_write ? TGT_CLKCTL : TGT_STAT;
                3'd7:    target = TGT_RESET;
                default: target = TGT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ibr_timer.sv
module ibr_timer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last = st_q.busy && (st_q.cnt == '0);
        if (last) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(LATENCY - 1);
        end
        busy = st_q.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.cnt) <= LATENCY - 1));
    p_cnt_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ind_reg_bridge_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              acc_stb,
    output logic              acc_wr,
    output logic [2:0]        acc_sel,
    output logic [7:0]        acc_wdata,
    input  logic [7:0]        acc_rdata
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
    } br_t;

    br_t     st_d, st_q;
    target_e tgt;
    logic    is_wr;
    logic    busy, last, start;

    ibr_decode u_dec (
        .cmd      (st_q.word),
        .target   (tgt),
        .is_write (is_wr)
    );

    ibr_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .last  (last)
    );

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (busy) begin
            if (last) begin
                st_d.word[BIT_VALID] = 1'b0;
                if (!is_wr && tgt != TGT_NONE)
                    st_d.word[BYTE_W-1:0] = acc_rdata;
            end
        end else if (host_we) begin
            st_d.word = host_wdata;
            start     = host_wdata[BIT_VALID];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.word;
    assign acc_stb    = last && (tgt != TGT_NONE);
    assign acc_wr     = is_wr;
    assign acc_sel    = tgt;
    assign acc_wdata  = st_q.word[BYTE_W-1:0];

    p_stb_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> host_rdata[63]);
    p_stb_then_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |=> !host_rdata[63]);
    p_upper_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[63] && $past(host_rdata[63])) |-> $stable(host_rdata[62:8]));
    p_flag_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[63] == busy);
    p_stb_mapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> (acc_sel != 3'd0 && acc_sel != 3'd7));
    p_dir_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> (acc_wr == !host_rdata[56]));
endmodule

// File: tb/ind_reg_bridge_test.sv
module ind_reg_bridge_test;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        acc_stb, acc_wr;
    logic [2:0]  acc_sel;
    logic [7:0]  acc_wdata, acc_rdata;

    int n_run = 0, n_fail = 0;
    int stb_cnt = 0;
    logic [2:0] seen_sel;
    logic       seen_wr;
    logic [7:0] seen_wdata;
    logic       seen_last;

    always #2.5 clk = ~clk;

    assign acc_rdata = 8'h3C + 8'(acc_sel) * 8'd17;

    ind_reg_bridge #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .acc_stb(acc_stb), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    always @(negedge clk) begin
        if (acc_stb) begin
            stb_cnt    = stb_cnt + 1;
            seen_sel   = acc_sel;
            seen_wr    = acc_wr;
            seen_wdata = acc_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_sel(input logic [63:0] w);
        logic [2:0] c;
        c = w[34:32];
        if (w[59] && !w[58]) return 3'd6;
        if (!(w[59] && w[58])) return 3'd0;
        case (c)
            3'd1: return 3'd1;
            3'd2: return 3'd2;
            3'd3: return w[56] ? 3'd4 : 3'd3;
            3'd7: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    // Issue one command, optionally poke a second word while busy (R3).
    task automatic run_cmd(input logic [63:0] w, input bit poke, input logic [63:0] pw);
        int vcyc;
        logic [2:0] es;
        logic [63:0] exp_word;
        es = exp_sel(w);
        @(negedge clk);
        stb_cnt = 0;
        host_we = 1'b1; host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
        vcyc = 0;
        while (host_rdata[63] && vcyc < 20) begin
            if (poke && vcyc == 1) begin
                host_we = 1'b1; host_wdata = pw;
            end else begin
                host_we = 1'b0;
            end
            vcyc++;
            @(negedge clk);
        end
        host_we = 1'b0;
        check(vcyc == LAT, "R2 busy cycles", 64'(vcyc), 64'(LAT));
        exp_word = {1'b0, w[62:0]};
        if (es != 3'd0) begin
            check(stb_cnt == 1, "R10 strobe count", 64'(stb_cnt), 64'd1);
            check(seen_sel == es, "R5/R6 selector", 64'(seen_sel), 64'(es));
            check(seen_wr == !w[56], "R4 direction", 64'(seen_wr), 64'(!w[56]));
            if (!w[56]) begin
                check(seen_wdata == w[7:0], "R8 payload", 64'(seen_wdata), 64'(w[7:0]));
            end else begin
                exp_word[7:0] = 8'h3C + 8'(es) * 8'd17;
            end
        end else begin
            check(stb_cnt == 0, "R7 no strobe", 64'(stb_cnt), 64'd0);
        end
        check(host_rdata == exp_word, w[56] ? "R9 readback" : "R8 word kept", host_rdata, exp_word);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        check(host_rdata == 64'd0, "R1 reset word", host_rdata, 64'd0);
        check(acc_stb == 1'b0, "R1 reset strobe", 64'(acc_stb), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: idle write without valid is stored, no access
        stb_cnt = 0;
        host_we = 1'b1; host_wdata = 64'h0F00_00A5_1234_5678;
        @(negedge clk);
        host_we = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check(host_rdata == 64'h0F00_00A5_1234_5678, "R11 stored", host_rdata, 64'h0F00_00A5_1234_5678);
        check(stb_cnt == 0, "R11 no strobe", 64'(stb_cnt), 64'd0);

        // Sweep: extended bits x code x direction
        for (int hi = 0; hi < 4; hi++) begin
            for (int c = 0; c < 8; c++) begin
                for (int rd = 0; rd < 2; rd++) begin
                    int idx;
                    idx = hi * 16 + c * 2 + rd;
                    w = 64'd0;
                    w[63]    = 1'b1;
                    w[62:60] = 3'(idx);
                    w[59:58] = 2'(hi);
                    w[56]    = 1'(rd);
                    w[47:40] = 8'(idx * 3 + 1);
                    w[34:32] = 3'(c);
                    w[23:8]  = 16'(idx * 911);
                    w[7:0]   = 8'(idx * 37 + 5);
                    run_cmd(w, 1'b0, 64'd0);
                end
            end
        end

        // R3: write while busy ignored (write access, poke targets thp read)
        run_cmd(64'h8C00_0001_0000_0042, 1'b1, 64'h8900_0000_0000_00FF);
        // R3: read access poked with a write to data register
        run_cmd(64'h8D00_0003_0000_0011, 1'b1, 64'h8C00_0001_0000_0077);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule